// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers event signals from a power-management companion into one 16-bit status word and drives a single interrupt request line. Three single-cycle event pulses come from a real-time-clock section: a periodic tick, an alarm match and an update error. A level input comes from a power button. Each event sets a fixed status bit that stays set until software clears it.

Software reaches the block through a byte-wide register port. Each half of the 16-bit word has its own byte address, and the same split applies to the mask, to the status and to a write-one-to-clear acknowledge register. A mask bit at 1 blocks its status bit from the interrupt line. Three general-purpose input lines are sampled into a readable register but never cause an interrupt.

The register map, at `reg_addr`, is: 0 mask bits 7:0, 1 mask bits 15:8, 2 status bits 7:0, 3 status bits 15:8, 4 acknowledge bits 7:0, 5 acknowledge bits 15:8, 6 sampled GPIO. Reads are combinational from `reg_addr`. Writes take effect at the clock edge where `wr_en` is high.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the mask word reads 0x0FFF (address 0 reads 0xFF, address 1 reads 0x0F), both status bytes read 0 and `irq_o` is 0.
- R2: `irq_o` equals the OR over all bits of (status AND NOT mask), as those values stood one clock earlier, so it changes one cycle after any status or mask change.
- R3: A write to address 0 replaces mask bits 7:0 and leaves bits 15:8 unchanged. A write to address 1 replaces mask bits 15:8 and leaves bits 7:0 unchanged.
- R4: A write to address 4 or 5 clears each status bit of that byte (7:0 or 15:8) whose written bit is 1. All other status bits are left unchanged.
- R5: Reading address 4 or 5 returns 0, as does reading address 7.
- R6: An `ev_rtc_tick` pulse sets status bit 8, `ev_rtc_alarm` sets bit 9 and `ev_rtc_error` sets bit 10. These bits read back as bits 0, 1 and 2 of address 3.
- R7: Status bit 11 is set only in a cycle where `pwr_btn` is 1 and its stored value from the previous cycle is 0. Holding the button high does not set the bit again once it has been acknowledged.
- R8: `gpio_in` is sampled every clock into a register that reads at address 6, in bits 2:0, with upper bits 0. It never sets any status bit.
- R9: When an event sets a status bit in the same cycle that an acknowledge clears that bit, the bit ends up set.
- R10: Writes to the status addresses 2 and 3 have no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte address |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, combinational from `reg_addr` |
| ev_rtc_tick | input | 1 | Periodic tick event pulse |
| ev_rtc_alarm | input | 1 | Alarm match event pulse |
| ev_rtc_error | input | 1 | Update error event pulse |
| pwr_btn | input | 1 | Power button level |
| gpio_in | input | 3 | Plain general-purpose inputs |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse in the exact cycle where an acknowledge write clears the same bit. The stimulus asserts the tick pulse and the acknowledge write on the same falling edge, so the two meet at one rising edge. The power-button edge rule is exercised by holding the button high across an acknowledge. The mask is swept over every combination of the four event bits, against every combination of set status bits. Each point of that sweep is checked against an irq value computed in the bench, one clock after the mask write lands.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Fixed status bit positions of the event sources
  localparam int BIT_TICK   = 8;
  localparam int BIT_ALARM  = 9;
  localparam int BIT_ERROR  = 10;
  localparam int BIT_BUTTON = 11;
  localparam int BIT_TOP    = BIT_BUTTON;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int STAT_W = 16,
  parameter int BYTE_W = 8,
  parameter logic [STAT_W-1:0] MASK_RST = 16'h0FFF,
  localparam int NB = STAT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     lane_wr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [STAT_W-1:0] mask_q
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)          mask_q[i*BYTE_W +: BYTE_W] <= MASK_RST[i*BYTE_W +: BYTE_W];
      else if (lane_wr[i]) mask_q[i*BYTE_W +: BYTE_W] <= wr_data;
    end

    AST_MASK_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_wr[i] |=> $stable(mask_q[i*BYTE_W +: BYTE_W])); // R3
  end
endmodule

// File: rtl/irq_event_map.sv
module irq_event_map
  import irq_agg_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tick,
  input  logic              ev_alarm,
  input  logic              ev_error,
  input  logic              btn_level,
  output logic              btn_rise,
  output logic [STAT_W-1:0] set_vec
);
  logic btn_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) btn_prev <= 1'b0;
    else        btn_prev <= btn_level;
  end

  assign btn_rise = btn_level & ~btn_prev;

  always_comb begin
    set_vec             = '0;
    set_vec[BIT_TICK]   = ev_tick;
    set_vec[BIT_ALARM]  = ev_alarm;
    set_vec[BIT_ERROR]  = ev_error;
    set_vec[BIT_BUTTON] = btn_rise;
  end

  AST_BTN_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    btn_rise |=> !btn_rise); // R7
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int STAT_W = 16,
  parameter int BYTE_W = 8,
  localparam int NB = STAT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     lane_ack,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [STAT_W-1:0] set_vec,
  output logic [STAT_W-1:0] status_q
);
  logic [STAT_W-1:0] clr_vec;

  // Set has priority over clear within one edge
  function automatic logic [STAT_W-1:0] next_status(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] clr,
    input logic [STAT_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  for (genvar i = 0; i < NB; i++) begin : g_ack
    assign clr_vec[i*BYTE_W +: BYTE_W] = lane_ack[i] ? wr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, clr_vec, set_vec);
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0 && set_vec == '0) |=> ((status_q & $past(clr_vec)) == '0)); // R4
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R9
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0 && set_vec == '0) |=> $stable(status_q)); // R10
endmodule

// File: rtl/irq_line_out.sv
module irq_line_out #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_q,
  input  logic [STAT_W-1:0] mask_q,
  output logic              irq_o
);
  logic pending;

  function automatic logic any_pending(input logic [STAT_W-1:0] st,
                                       input logic [STAT_W-1:0] mk);
    return |(st & ~mk);
  endfunction

  assign pending = any_pending(status_q, mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pending;
  end

  AST_IRQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(pending) |=> (irq_o == $past(pending))); // R2
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int STAT_W   = 16,
  parameter int BYTE_W   = 8,
  parameter int NUM_GPIO = 3,
  parameter int AW       = 3,
  parameter logic [STAT_W-1:0] MASK_RST = 16'h0FFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       reg_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                ev_rtc_tick,
  input  logic                ev_rtc_alarm,
  input  logic                ev_rtc_error,
  input  logic                pwr_btn,
  input  logic [NUM_GPIO-1:0] gpio_in,
  output logic                irq_o
);
  localparam int NB        = STAT_W / BYTE_W;
  localparam int MASK_BASE = 0;
  localparam int STAT_BASE = NB;
  localparam int ACK_BASE  = 2 * NB;
  localparam int GPIO_ADDR = 3 * NB;

  logic [NB-1:0]       mask_lane_wr;
  logic [NB-1:0]       ack_lane_wr;
  logic [NB-1:0]       ack_lane_sel;
  logic                is_ack_addr;
  logic [STAT_W-1:0]   mask_q;
  logic [STAT_W-1:0]   status_q;
  logic [STAT_W-1:0]   set_vec;
  logic                btn_rise;
  logic [NUM_GPIO-1:0] gpio_q;

  for (genvar i = 0; i < NB; i++) begin : g_dec
    assign mask_lane_wr[i] = wr_en && (reg_addr == AW'(MASK_BASE + i));
    assign ack_lane_sel[i] = (reg_addr == AW'(ACK_BASE + i));
    assign ack_lane_wr[i]  = wr_en && ack_lane_sel[i];
  end
  assign is_ack_addr = |ack_lane_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) gpio_q <= '0;
    else        gpio_q <= gpio_in;
  end

  irq_mask_reg #(.STAT_W(STAT_W), .BYTE_W(BYTE_W), .MASK_RST(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .lane_wr(mask_lane_wr), .wr_data(wr_data), .mask_q(mask_q));

  irq_event_map #(.STAT_W(STAT_W)) u_events (
    .clk(clk), .rst_n(rst_n), .ev_tick(ev_rtc_tick), .ev_alarm(ev_rtc_alarm),
    .ev_error(ev_rtc_error), .btn_level(pwr_btn), .btn_rise(btn_rise), .set_vec(set_vec));

  irq_status_reg #(.STAT_W(STAT_W), .BYTE_W(BYTE_W)) u_status (
    .clk(clk), .rst_n(rst_n), .lane_ack(ack_lane_wr), .wr_data(wr_data),
    .set_vec(set_vec), .status_q(status_q));

  irq_line_out #(.STAT_W(STAT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .status_q(status_q), .mask_q(mask_q), .irq_o(irq_o));

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == AW'(MASK_BASE + i)) rd_data = mask_q[i*BYTE_W +: BYTE_W];
      if (reg_addr == AW'(STAT_BASE + i)) rd_data = status_q[i*BYTE_W +: BYTE_W];
    end
    if (reg_addr == AW'(GPIO_ADDR)) rd_data[NUM_GPIO-1:0] = gpio_q;
  end

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_ack_addr |-> (rd_data == '0)); // R5
  AST_BTN_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    btn_rise |=> status_q[BIT_BUTTON]); // R7
endmodule

// File: tb/irq_status_agg_test.sv
`timescale 1ns/1ps
module irq_status_agg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ev_rtc_tick = 1'b0, ev_rtc_alarm = 1'b0, ev_rtc_error = 1'b0;
  logic       pwr_btn = 1'b0;
  logic [2:0] gpio_in = '0;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [2:0] A_MLO = 3'd0, A_MHI = 3'd1, A_SLO = 3'd2, A_SHI = 3'd3,
                         A_KLO = 3'd4, A_KHI = 3'd5, A_GPI = 3'd6, A_NONE = 3'd7;

  always #4 clk = ~clk;

  irq_status_agg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .ev_rtc_tick(ev_rtc_tick), .ev_rtc_alarm(ev_rtc_alarm),
    .ev_rtc_error(ev_rtc_error), .pwr_btn(pwr_btn), .gpio_in(gpio_in), .irq_o(irq_o));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = rd_data;
  endtask

  // ev[0] tick, ev[1] alarm, ev[2] error, ev[3] button rise
  task automatic pulse(input logic [3:0] ev);
    @(negedge clk);
    ev_rtc_tick = ev[0]; ev_rtc_alarm = ev[1]; ev_rtc_error = ev[2]; pwr_btn = ev[3];
    @(negedge clk);
    ev_rtc_tick = 1'b0; ev_rtc_alarm = 1'b0; ev_rtc_error = 1'b0; pwr_btn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_MLO, d); chk("R1 mask lo", 16'(d), 16'h00FF);
    rd(A_MHI, d); chk("R1 mask hi", 16'(d), 16'h000F);
    rd(A_SLO, d); chk("R1 status lo", 16'(d), 16'h0000);
    rd(A_SHI, d); chk("R1 status hi", 16'(d), 16'h0000);
    chk("R1 irq", 16'(irq_o), 16'h0);

    // R3 split mask bytes
    wr(A_MLO, 8'h5A);
    rd(A_MLO, d); chk("R3 lo written", 16'(d), 16'h005A);
    rd(A_MHI, d); chk("R3 hi kept", 16'(d), 16'h000F);
    wr(A_MHI, 8'h33);
    rd(A_MHI, d); chk("R3 hi written", 16'(d), 16'h0033);
    rd(A_MLO, d); chk("R3 lo kept", 16'(d), 16'h005A);
    wr(A_MLO, 8'hFF); wr(A_MHI, 8'h0F);

    // R6 exhaustive over event sets, R2 over mask nibbles
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 16; m++) begin
        pulse(4'(s));
        wr(A_MHI, 8'(m));
        @(negedge clk);
        chk("R2 irq vs mask", 16'(irq_o), 16'(|(4'(s) & ~4'(m))));
        rd(A_SHI, d); chk("R6 event bits", 16'(d), 16'(s));
        wr(A_KHI, 8'hFF);
        wr(A_MHI, 8'h0F);
      end
    end

    // R2 latency: status visible, irq one clock later
    wr(A_MHI, 8'h00);
    pulse(4'b0001);
    rd(A_SHI, d); chk("R2 status visible", 16'(d), 16'h0001);
    chk("R2 irq not yet", 16'(irq_o), 16'h0);
    @(negedge clk);
    chk("R2 irq after one clock", 16'(irq_o), 16'h1);

    // R5 ack reads zero
    rd(A_KLO, d); chk("R5 ack lo read", 16'(d), 16'h0);
    rd(A_KHI, d); chk("R5 ack hi read", 16'(d), 16'h0);
    rd(A_NONE, d); chk("R5 unmapped read", 16'(d), 16'h0);

    // R4 partial acknowledge
    pulse(4'b1111);
    rd(A_SHI, d); chk("R4 all set", 16'(d), 16'h000F);
    wr(A_KHI, 8'h05);
    rd(A_SHI, d); chk("R4 partial clear", 16'(d), 16'h000A);
    wr(A_KLO, 8'hFF);
    rd(A_SHI, d); chk("R4 low ack leaves high", 16'(d), 16'h000A);
    wr(A_KHI, 8'h0A);
    rd(A_SHI, d); chk("R4 cleared", 16'(d), 16'h0000);
    @(negedge clk);
    chk("R4 irq drops", 16'(irq_o), 16'h0);

    // R10 status writes ignored
    pulse(4'b0010);
    wr(A_SHI, 8'h00);
    rd(A_SHI, d); chk("R10 status hi write ignored", 16'(d), 16'h0002);
    wr(A_SLO, 8'hFF);
    rd(A_SLO, d); chk("R10 status lo write ignored", 16'(d), 16'h0000);
    wr(A_KHI, 8'hFF);

    // R9 set and ack of same bit in one cycle
    @(negedge clk);
    wr_en = 1'b1; reg_addr = A_KHI; wr_data = 8'h01; ev_rtc_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev_rtc_tick = 1'b0;
    rd(A_SHI, d); chk("R9 set wins over ack", 16'(d), 16'h0001);
    pulse(4'b0010);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = A_KHI; wr_data = 8'h03; ev_rtc_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev_rtc_tick = 1'b0;
    rd(A_SHI, d); chk("R9 other bit cleared", 16'(d), 16'h0001);
    wr(A_KHI, 8'hFF);

    // R7 button held high
    @(negedge clk); pwr_btn = 1'b1;
    @(negedge clk);
    rd(A_SHI, d); chk("R7 rise sets", 16'(d), 16'h0008);
    wr(A_KHI, 8'h08);
    repeat (4) @(negedge clk);
    rd(A_SHI, d); chk("R7 held no reset", 16'(d), 16'h0000);
    pwr_btn = 1'b0;
    @(negedge clk);
    rd(A_SHI, d); chk("R7 fall no set", 16'(d), 16'h0000);
    pwr_btn = 1'b1;
    @(negedge clk);
    rd(A_SHI, d); chk("R7 second rise", 16'(d), 16'h0008);
    pwr_btn = 1'b0;
    wr(A_KHI, 8'hFF);

    // R8 GPIO sampling, never interrupts (all unmasked)
    wr(A_MLO, 8'h00);
    for (int g = 0; g < 8; g++) begin
      @(negedge clk); gpio_in = 3'(g);
      @(negedge clk);
      rd(A_GPI, d); chk("R8 gpio value", 16'(d), 16'(g));
      rd(A_SLO, d); chk("R8 status lo untouched", 16'(d), 16'h0);
      rd(A_SHI, d); chk("R8 status hi untouched", 16'(d), 16'h0);
      @(negedge clk);
      chk("R8 no irq", 16'(irq_o), 16'h0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule